// File: doc/BRIEF.md
# Masked Interrupt Event Unit

This unit collects the event conditions of an Ethernet MAC and turns them into thirteen separate level interrupt lines. It holds a pending-event word and a mask word, both 32 bits wide. Only the top thirteen bits carry events. Event sources inside the MAC raise pending bits with one-cycle set pulses. Software reads both words, clears pending bits by writing ones, and loads the mask with a plain write. A write to the transmit control address with bit 0 set marks the graceful-stop event as complete straight away.

Each output line follows one event class. A line is high when that class is both pending and unmasked. The lines come out of registers. The lines use a fixed order that differs from the order of the event bits, so that each event class can go to its own interrupt input.

Top module: `irq_event_unit`

## Requirements
- R1: `evt_set[k]` sets pending bit 19+k. The pending word reads at address 0. From bit 31 down to bit 19 the bits are: heartbeat, babbling receive, babbling transmit, graceful stop, tx frame, tx buffer, rx frame, rx buffer, MII done, bus error, late collision, retry limit, underrun.
- R2: A write to address 0 clears each pending bit written as one and leaves the other pending bits unchanged.
- R3: A write to address 1 replaces the whole mask. The mask reads back at address 1.
- R4: Lines 0 to 12 carry these pending bits in order: 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30. A line is high exactly when its pending bit and its mask bit are both set.
- R5: A line changes one clock after the pending or mask state that drives it. This is two rising edges after the write or the set pulse is sampled.
- R6: `soft_reset` clears the pending word and the mask word on the next edge. It wins over a set pulse in the same cycle.
- R7: A write to address 2 with bit 0 set raises pending bit 28 (graceful stop). Such a write with bit 0 clear changes nothing. Address 2 reads as zero.
- R8: If a set pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: Bits 18:0 of the pending word and the mask word always read as zero. Writes to those bits are ignored. Address 3 reads as zero.
- R10: After `rst`, both words read zero and all lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_reset | input | 1 | Clears pending and mask words |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 pending, 1 mask, 2 transmit control |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| evt_set | input | 13 | Event set pulses, bit k for pending bit 19+k |
| irq_line | output | 13 | Registered level interrupt lines |

## Verification
If the permutation is wrong, one event lights the wrong line. This shows two edges after a single set pulse, so the table of single-event cases finds it at once. If the clear or mask logic is wrong, the read port shows it on the next cycle, because both words read back directly. A wrong priority between set, clear and soft reset shows only in cases where these collide in the same cycle, and directed tests force those cases.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
    parameter int DATA_W  = 32;
    parameter int NUM_EVT = 13;
    localparam int EVT_LSB = DATA_W - NUM_EVT;

    typedef enum logic [1:0] {
        SEL_PEND  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_TXCTL = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                en;
        reg_sel_e            sel;
        logic [DATA_W-1:0]   data;
    } reg_wr_t;

    // event index k = pending bit - EVT_LSB
    localparam int EV_GSTOP = 9;

    // pending-event index feeding each output line
    function automatic int unsigned line_src(input int unsigned line);
        case (line)
            0:  return 8;
            1:  return 7;
            2:  return 0;
            3:  return 1;
            4:  return 6;
            5:  return 5;
            6:  return 4;
            7:  return 2;
            8:  return 12;
            9:  return 9;
            10: return 3;
            11: return 10;
            default: return 11;
        endcase
    endfunction

    function automatic logic [NUM_EVT-1:0] route(input logic [NUM_EVT-1:0] act);
        logic [NUM_EVT-1:0] r;
        for (int i = 0; i < NUM_EVT; i++) r[i] = act[line_src(i)];
        return r;
    endfunction
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_reset,
    input  logic [NUM_EVT-1:0] clr,
    input  logic [NUM_EVT-1:0] set,
    output logic [NUM_EVT-1:0] pend_q
);
    always_ff @(posedge clk) begin
        if (rst || soft_reset)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr) | set;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_reset,
    input  logic               load,
    input  logic [NUM_EVT-1:0] din,
    output logic [NUM_EVT-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst || soft_reset)
            mask_q <= '0;
        else if (load)
            mask_q <= din;
    end
endmodule

// File: rtl/irq_line_map.sv
module irq_line_map
    import irq_evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] pend,
    input  logic [NUM_EVT-1:0] mask,
    output logic [NUM_EVT-1:0] lines
);
    logic [NUM_EVT-1:0] act;
    assign act = pend & mask;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_line
        localparam int unsigned SRC = line_src(g);
        always_ff @(posedge clk) begin
            if (rst) lines[g] <= 1'b0;
            else     lines[g] <= act[SRC];
        end
    end
endmodule

// File: rtl/irq_event_unit.sv
module irq_event_unit
    import irq_evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_reset,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [1:0]         rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_EVT-1:0] evt_set,
    output logic [NUM_EVT-1:0] irq_line
);
    reg_wr_t            wreq;
    logic [NUM_EVT-1:0] pend_q, mask_q, clr_v, set_v;
    logic               gstop_req;

    assign wreq = '{en: wr_en, sel: reg_sel_e'(wr_addr), data: wr_data};

    assign clr_v     = (wreq.en && wreq.sel == SEL_PEND) ? wreq.data[DATA_W-1:EVT_LSB] : '0;
    assign gstop_req = wreq.en && wreq.sel == SEL_TXCTL && wreq.data[0];

    always_comb begin
        set_v = evt_set;
        if (gstop_req) set_v[EV_GSTOP] = 1'b1;
    end

    irq_pend_reg u_pend (
        .clk(clk), .rst(rst), .soft_reset(soft_reset),
        .clr(clr_v), .set(set_v), .pend_q(pend_q)
    );

    irq_mask_reg u_mask (
        .clk(clk), .rst(rst), .soft_reset(soft_reset),
        .load(wreq.en && wreq.sel == SEL_MASK),
        .din(wreq.data[DATA_W-1:EVT_LSB]), .mask_q(mask_q)
    );

    irq_line_map u_map (
        .clk(clk), .rst(rst), .pend(pend_q), .mask(mask_q), .lines(irq_line)
    );

    always_comb begin
        case (reg_sel_e'(rd_addr))
            SEL_PEND: rd_data = {pend_q, {EVT_LSB{1'b0}}};
            SEL_MASK: rd_data = {mask_q, {EVT_LSB{1'b0}}};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_event_unit_chk.sv
module irq_event_unit_chk
    import irq_evt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               soft_reset,
    input logic               wr_en,
    input logic [1:0]         wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [1:0]         rd_addr,
    input logic [DATA_W-1:0]  rd_data,
    input logic [NUM_EVT-1:0] evt_set,
    input logic [NUM_EVT-1:0] irq_line,
    input logic [NUM_EVT-1:0] pend_q,
    input logic [NUM_EVT-1:0] mask_q
);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!soft_reset && evt_set != 0) |=> ((pend_q & $past(evt_set)) == $past(evt_set)));

    // R2
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (!soft_reset && evt_set == 0 && wr_en && wr_addr == 2'd0)
        |=> (pend_q == ($past(pend_q) & ~$past(wr_data[DATA_W-1:EVT_LSB]))));

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!soft_reset && wr_en && wr_addr == 2'd1)
        |=> (mask_q == $past(wr_data[DATA_W-1:EVT_LSB])));

    // R6
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_reset |=> (pend_q == 0 && mask_q == 0));

    // R7
    gstop_chk: assert property (@(posedge clk) disable iff (rst)
        (!soft_reset && wr_en && wr_addr == 2'd2 && wr_data[0]) |=> pend_q[EV_GSTOP]);

    // R4
    line_route_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_line == route($past(pend_q & mask_q))));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[EVT_LSB-1:0] == 0);
endmodule

bind irq_event_unit irq_event_unit_chk u_chk (
    .clk(clk), .rst(rst), .soft_reset(soft_reset), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_set(evt_set), .irq_line(irq_line), .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/irq_event_unit_bench.sv
module irq_event_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_reset = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [12:0] evt_set = '0;
    logic [12:0] irq_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_event_unit u_irq_event_unit (
        .clk(clk), .rst(rst), .soft_reset(soft_reset), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .evt_set(evt_set), .irq_line(irq_line)
    );

    // {set pulse, mask word, expected lines}
    typedef struct packed {
        logic [12:0] set;
        logic [31:0] mask;
        logic [12:0] exp;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{13'h1FFF, 32'hFFF80000, 13'h1FFF},
        '{13'h1FFF, 32'h00000000, 13'h0000},
        '{13'h0100, 32'h08000000, 13'h0001},
        '{13'h1000, 32'h80000000, 13'h0100},
        '{13'h0001, 32'h00080000, 13'h0004},
        '{13'h0800, 32'h40000000, 13'h1000},
        '{13'h0400, 32'hFFFFFFFF, 13'h0800},
        '{13'h0008, 32'hFFF80000, 13'h0400},
        '{13'h0004, 32'hFFFFFFFF, 13'h0080},
        '{13'h0200, 32'hFFFFFFFF, 13'h0200},
        '{13'h1FFF, 32'h00800000, 13'h0040},
        '{13'h0002, 32'hFFFFFFFF, 13'h0008}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [12:0] s);
        evt_set = s;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
        rd_addr = a; #1;
        check(req, rd_data, exp);
    endtask

    task automatic sreset();
        soft_reset = 1'b1;
        @(negedge clk);
        soft_reset = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        rd_check("R10 pending", 2'd0, 32'h0);
        rd_check("R10 mask", 2'd1, 32'h0);
        check("R10 lines", {19'h0, irq_line}, 32'h0);

        // R1 R3 R4 routing table
        foreach (VECS[i]) begin
            sreset();
            wr(2'd1, VECS[i].mask);
            pulse(VECS[i].set);
            @(negedge clk);
            check("R4 lines", {19'h0, irq_line}, {19'h0, VECS[i].exp});
            rd_check("R1 pending", 2'd0, {VECS[i].set, 19'h0});
            rd_check("R3 mask", 2'd1, VECS[i].mask & 32'hFFF80000);
        end

        // R5 latency
        sreset();
        wr(2'd1, 32'hFFFFFFFF);
        pulse(13'h0100);
        check("R5 lines one edge after pulse", {19'h0, irq_line}, 32'h0);
        @(negedge clk);
        check("R5 lines two edges after pulse", {19'h0, irq_line}, 32'h1);

        // R2 write one to clear
        sreset();
        pulse(13'h1FFF);
        wr(2'd0, 32'hF0000000);
        rd_check("R2 partial clear", 2'd0, 32'h0FF80000);
        wr(2'd0, 32'h00000000);
        rd_check("R2 zero write no effect", 2'd0, 32'h0FF80000);

        // R8 set beats clear
        evt_set = 13'h0100; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'hFFFFFFFF;
        @(negedge clk);
        evt_set = '0; wr_en = 1'b0;
        rd_check("R8 set wins", 2'd0, 32'h08000000);

        // R6 soft reset wins over set
        wr(2'd1, 32'hFFFFFFFF);
        soft_reset = 1'b1; evt_set = 13'h1FFF;
        @(negedge clk);
        soft_reset = 1'b0; evt_set = '0;
        rd_check("R6 pending cleared", 2'd0, 32'h0);
        rd_check("R6 mask cleared", 2'd1, 32'h0);
        @(negedge clk);
        check("R6 lines low", {19'h0, irq_line}, 32'h0);

        // R7 transmit control
        wr(2'd2, 32'h00000002);
        rd_check("R7 bit0 clear no effect", 2'd0, 32'h0);
        wr(2'd2, 32'h00000001);
        rd_check("R7 graceful stop raised", 2'd0, 32'h10000000);
        rd_check("R7 txctl reads zero", 2'd2, 32'h0);
        wr(2'd1, 32'h10000000);
        @(negedge clk);
        check("R7 line 9", {19'h0, irq_line}, 32'h200);

        // R9 reserved bits
        sreset();
        wr(2'd1, 32'hFFFFFFFF);
        rd_check("R9 mask reserved", 2'd1, 32'hFFF80000);
        wr(2'd0, 32'h0007FFFF);
        rd_check("R9 pending reserved", 2'd0, 32'h0);
        rd_check("R9 addr3 zero", 2'd3, 32'h0);

        finish_run();
    end
endmodule